// File: doc/BRIEF.md
# Parallel-Lane Stride Reorderer

This block takes one frame of FRAME complex samples that arrives LANES samples per beat and hands it back out LANES samples per beat in the other index order. A frame therefore takes STRIDE = FRAME/LANES beats on each side. Two orders exist. In the contiguous order, beat k holds frame indexes kP to kP+P-1 (P = LANES). In the strided order, beat k holds k, k+STRIDE, k+2·STRIDE, up to k+(P-1)·STRIDE. The block can convert in either direction. The input order of each frame is picked on its first input beat by the `in_strided` pin. The output always uses the opposite order, so the block can sit after a unit that emits strided bins or feed one that wants them.

Storage is two frame banks used in ping-pong. One frame can drain while the next fills, so with both sides always ready the flow runs one beat per cycle. Both ends use valid/ready handshakes. Every output beat carries a vector holding the frame index of each lane, so downstream logic never has to track the order itself.

Top module: `stride_reorder`

## Requirements
- R1: While `rst` is high, `in_ready` and `out_valid` are low. After a synchronous reset with no traffic, `in_ready` is high and `out_valid` is low.
- R2: With `in_strided`=0, input beat k lane j (bits j·DATA_W upward) carries frame index k·LANES+j. Output beat k lane j then carries the sample of index k+j·STRIDE.
- R3: With `in_strided`=1, input beat k lane j carries frame index k+j·STRIDE. Output beat k lane j then carries the sample of index k·LANES+j.
- R4: Field j of `out_idx` (bits j·IDX_W upward, IDX_W = log2 FRAME) equals the frame index of the sample in output lane j. The real and imaginary parts are moved identically.
- R5: The order of a frame is taken from `in_strided` on its first accepted beat. Values of `in_strided` on later beats of that frame have no effect.
- R6: `out_valid` stays low until the last (STRIDE-th) beat of a frame is accepted, and it goes high in the next cycle.
- R7: Up to two complete frames are held. `in_ready` falls only while both banks are full, and input resumes once the older frame has been read out.
- R8: A beat moves only on a cycle where valid and ready are both high. Data offered with `in_valid` low is ignored. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re`, `out_im` and `out_idx` hold their values.
- R9: Frames leave in the order they arrived, each as exactly STRIDE output beats.
- R10: A reset during a partly written frame discards that frame. The next frame starts again at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can accept an input beat |
| in_strided | input | 1 | Order of the frame starting on this beat: 0 contiguous, 1 strided |
| in_re | input | LANES·DATA_W | Real parts, lane j at bits j·DATA_W |
| in_im | input | LANES·DATA_W | Imaginary parts, same lane layout |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_re | output | LANES·DATA_W | Real parts of the reordered beat |
| out_im | output | LANES·DATA_W | Imaginary parts of the reordered beat |
| out_idx | output | LANES·IDX_W | Frame index of each output lane |

## Verification
The bench sends ramp frames in which each sample's value encodes both its frame number and its index. A lane that reads the wrong address, the wrong bank or the wrong frame therefore shows up as a value that does not match the reported index. Frames in the two orders are interleaved, both back to back and in random mixes, which separates the two address maps and catches a bank that keeps a stale order. Random idle gaps, random `out_ready` and garbage on `in_strided` after the first beat separate handshake and mode-latching faults from address faults. Directed cases cover a full stall with both banks loaded, the first-frame latency and a reset in the middle of a frame.

// File: rtl/stride_pkg.sv
package stride_pkg;

    typedef enum logic {
        ORDER_CONT   = 1'b0,
        ORDER_STRIDE = 1'b1
    } order_e;

    typedef struct packed {
        logic   full;
        order_e in_order;
    } bank_state_t;

    function automatic order_e flip_order(input order_e o);
        return (o == ORDER_CONT) ? ORDER_STRIDE : ORDER_CONT;
    endfunction

    // frame position of lane `lane` in beat `beat` for a given order
    function automatic int frame_index(input order_e o, input int beat,
                                       input int lane, input int lanes,
                                       input int stride);
        if (o == ORDER_STRIDE)
            return beat + lane * stride;
        return beat * lanes + lane;
    endfunction

endpackage

// File: rtl/stride_index_map.sv
module stride_index_map
    import stride_pkg::*;
#(
    parameter int LANES = 4,
    parameter int FRAME = 64,
    localparam int IDX_W  = $clog2(FRAME),
    localparam int STRIDE = FRAME / LANES,
    localparam int BEAT_W = $clog2(STRIDE)
) (
    input  order_e                   order,
    input  logic [BEAT_W-1:0]        beat,
    output logic [LANES*IDX_W-1:0]   idx
);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign idx[l*IDX_W +: IDX_W] =
                IDX_W'(frame_index(order, int'(beat), l, LANES, STRIDE));
        end
    endgenerate

endmodule

// File: rtl/stride_frame_store.sv
module stride_frame_store #(
    parameter int LANES  = 4,
    parameter int FRAME  = 64,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(FRAME),
    localparam int DEPTH = 2 * FRAME
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic                      wr_bank,
    input  logic [LANES*IDX_W-1:0]    wr_idx,
    input  logic [LANES*DATA_W-1:0]   wr_re,
    input  logic [LANES*DATA_W-1:0]   wr_im,
    input  logic                      rd_bank,
    input  logic [LANES*IDX_W-1:0]    rd_idx,
    output logic [LANES*DATA_W-1:0]   rd_re,
    output logic [LANES*DATA_W-1:0]   rd_im
);

    logic [DATA_W-1:0] re_mem [DEPTH];
    logic [DATA_W-1:0] im_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                re_mem[{wr_bank, wr_idx[l*IDX_W +: IDX_W]}] <= wr_re[l*DATA_W +: DATA_W];
                im_mem[{wr_bank, wr_idx[l*IDX_W +: IDX_W]}] <= wr_im[l*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_re[l*DATA_W +: DATA_W] = re_mem[{rd_bank, rd_idx[l*IDX_W +: IDX_W]}];
            rd_im[l*DATA_W +: DATA_W] = im_mem[{rd_bank, rd_idx[l*IDX_W +: IDX_W]}];
        end
    end

endmodule

// File: rtl/stride_bank_ctrl.sv
module stride_bank_ctrl
    import stride_pkg::*;
#(
    parameter int LANES = 4,
    parameter int FRAME = 64,
    localparam int STRIDE = FRAME / LANES,
    localparam int BEAT_W = $clog2(STRIDE),
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(STRIDE - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  order_e            in_order,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              wr_en,
    output logic              wr_bank,
    output logic [BEAT_W-1:0] wr_beat,
    output order_e            wr_order,
    output logic              rd_bank,
    output logic [BEAT_W-1:0] rd_beat,
    output order_e            rd_order
);

    bank_state_t       bank_q [2];
    logic              wr_bank_q, rd_bank_q;
    logic [BEAT_W-1:0] wr_beat_q, rd_beat_q;
    logic              accept, emit;

    assign in_ready  = !rst && !bank_q[wr_bank_q].full;
    assign out_valid = !rst &&  bank_q[rd_bank_q].full;
    assign accept    = in_valid && in_ready;
    assign emit      = out_valid && out_ready;

    // first beat takes the pin, later beats use the latched order
    assign wr_order = (wr_beat_q == '0) ? in_order : bank_q[wr_bank_q].in_order;
    assign rd_order = flip_order(bank_q[rd_bank_q].in_order);
    assign wr_en    = accept;
    assign wr_bank  = wr_bank_q;
    assign wr_beat  = wr_beat_q;
    assign rd_bank  = rd_bank_q;
    assign rd_beat  = rd_beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++) begin
                bank_q[b] <= '{full: 1'b0, in_order: ORDER_CONT};
            end
            wr_bank_q <= 1'b0;
            rd_bank_q <= 1'b0;
            wr_beat_q <= '0;
            rd_beat_q <= '0;
        end else begin
            if (accept) begin
                if (wr_beat_q == '0)
                    bank_q[wr_bank_q].in_order <= in_order;
                if (wr_beat_q == LAST_BEAT) begin
                    bank_q[wr_bank_q].full <= 1'b1;
                    wr_bank_q <= !wr_bank_q;
                    wr_beat_q <= '0;
                end else begin
                    wr_beat_q <= wr_beat_q + 1'b1;
                end
            end
            if (emit) begin
                if (rd_beat_q == LAST_BEAT) begin
                    bank_q[rd_bank_q].full <= 1'b0;
                    rd_bank_q <= !rd_bank_q;
                    rd_beat_q <= '0;
                end else begin
                    rd_beat_q <= rd_beat_q + 1'b1;
                end
            end
        end
    end

    // R6
    first_out_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(accept));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !emit |=> ($stable(rd_beat_q) && $stable(rd_bank_q)));

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(wr_beat_q) && $stable(wr_bank_q)));

endmodule

// File: rtl/stride_reorder.sv
module stride_reorder
    import stride_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int FRAME  = 64,
    parameter int DATA_W = 16,
    localparam int IDX_W  = $clog2(FRAME),
    localparam int STRIDE = FRAME / LANES,
    localparam int BEAT_W = $clog2(STRIDE)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_strided,
    input  logic [LANES*DATA_W-1:0] in_re,
    input  logic [LANES*DATA_W-1:0] in_im,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*DATA_W-1:0] out_re,
    output logic [LANES*DATA_W-1:0] out_im,
    output logic [LANES*IDX_W-1:0]  out_idx
);

    order_e            in_order, wr_order, rd_order;
    logic              wr_en, wr_bank, rd_bank;
    logic [BEAT_W-1:0] wr_beat, rd_beat;
    logic [LANES*IDX_W-1:0] wr_idx, rd_idx;

    assign in_order = in_strided ? ORDER_STRIDE : ORDER_CONT;

    stride_bank_ctrl #(.LANES(LANES), .FRAME(FRAME)) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_order(in_order),
        .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_beat(wr_beat), .wr_order(wr_order),
        .rd_bank(rd_bank), .rd_beat(rd_beat), .rd_order(rd_order)
    );

    stride_index_map #(.LANES(LANES), .FRAME(FRAME)) u_wr_map (
        .order(wr_order), .beat(wr_beat), .idx(wr_idx)
    );

    stride_index_map #(.LANES(LANES), .FRAME(FRAME)) u_rd_map (
        .order(rd_order), .beat(rd_beat), .idx(rd_idx)
    );

    stride_frame_store #(.LANES(LANES), .FRAME(FRAME), .DATA_W(DATA_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
        .wr_re(in_re), .wr_im(in_im), .rd_bank(rd_bank), .rd_idx(rd_idx),
        .rd_re(out_re), .rd_im(out_im)
    );

    assign out_idx = rd_idx;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> (!in_ready && !out_valid));

    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_idx)));

    // R4
    lane0_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_idx[IDX_W-1:0] == IDX_W'(STRIDE - 1)
         && rd_order == ORDER_STRIDE) |=> !$stable(out_idx) || !out_valid);

endmodule

// File: tb/stride_reorder_tb.sv
module stride_reorder_tb;

    localparam int P  = 4;
    localparam int N  = 64;
    localparam int DW = 16;
    localparam int IW = $clog2(N);
    localparam int M  = N / P;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_strided = 1'b0;
    logic [P*DW-1:0] in_re = '0;
    logic [P*DW-1:0] in_im = '0;
    logic out_ready;
    logic in_ready, out_valid;
    logic [P*DW-1:0] out_re, out_im;
    logic [P*IW-1:0] out_idx;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 1;
    int q_id[$];
    bit q_mode[$];
    int ob = 0;
    bit hold_pend = 0;
    logic [P*DW-1:0] h_re, h_im;
    logic [P*IW-1:0] h_idx;

    always #10 clk = ~clk;

    stride_reorder #(.LANES(P), .FRAME(N), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_strided(in_strided), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_re(out_re), .out_im(out_im), .out_idx(out_idx)
    );

    function automatic logic [DW-1:0] ramp(input int id, input int idx);
        return DW'((id << IW) | idx);
    endfunction

    function automatic int in_pos(input bit strided, input int k, input int j);
        return strided ? (k + j * M) : (k * P + j);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic drive_idle();
        in_valid   = 1'b0;
        in_strided = 1'($urandom % 2);
        in_re      = {$urandom, $urandom};
        in_im      = {$urandom, $urandom};
    endtask

    task automatic send_frame(input int id, input bit mode, input int max_gap,
                              input int nbeats, input bit watch_first);
        for (int k = 0; k < nbeats; k++) begin
            int gap;
            gap = (max_gap > 0) ? $urandom_range(max_gap, 0) : 0;
            repeat (gap) begin
                @(negedge clk);
                drive_idle();
            end
            @(negedge clk);
            in_valid   = 1'b1;
            // R5: only the first beat's in_strided counts
            in_strided = (k == 0) ? mode : 1'($urandom % 2);
            for (int j = 0; j < P; j++) begin
                in_re[j*DW +: DW] = ramp(id, in_pos(mode, k, j));
                in_im[j*DW +: DW] = ~ramp(id, in_pos(mode, k, j));
            end
            if (watch_first)
                check(out_valid == 1'b0, "R6", "out_valid before frame complete", out_valid, 0);
            while (!in_ready) @(negedge clk);
        end
        if (nbeats == M) begin
            q_id.push_back(id);
            q_mode.push_back(mode);
        end
        @(negedge clk);
        drive_idle();
        if (watch_first)
            check(out_valid == 1'b1, "R6", "out_valid after last beat", out_valid, 1);
    endtask

    // output side: choose ready, then check what transfers at the next edge
    always @(negedge clk) begin
        if (rst) begin
            out_ready = 1'b1;
            ob = 0;
            hold_pend = 0;
        end else begin
            logic r;
            case (rdy_mode)
                0:       r = 1'b0;
                1:       r = 1'b1;
                default: r = ($urandom % 4) != 0;
            endcase
            if (hold_pend) begin
                check(out_valid && out_re == h_re && out_im == h_im && out_idx == h_idx,
                      "R8", "output held under back-pressure", int'(out_valid), 1);
            end
            out_ready = r;
            hold_pend = out_valid && !r;
            h_re = out_re; h_im = out_im; h_idx = out_idx;
            if (out_valid && r) begin
                if (q_id.size() == 0) begin
                    check(1'b0, "R9", "output beat with no frame pending", ob, -1);
                end else begin
                    for (int j = 0; j < P; j++) begin
                        int e;
                        e = in_pos(!q_mode[0], ob, j);
                        check(int'(out_idx[j*IW +: IW]) == e, "R4", "lane index",
                              int'(out_idx[j*IW +: IW]), e);
                        check(out_re[j*DW +: DW] == ramp(q_id[0], e),
                              q_mode[0] ? "R3" : "R2", "lane real",
                              int'(out_re[j*DW +: DW]), int'(ramp(q_id[0], e)));
                        check(out_im[j*DW +: DW] == ~ramp(q_id[0], e), "R4", "lane imag",
                              int'(out_im[j*DW +: DW]), int'(~ramp(q_id[0], e)));
                    end
                    ob++;
                    if (ob == M) begin
                        ob = 0;
                        void'(q_id.pop_front());
                        void'(q_mode.pop_front());
                    end
                end
            end
        end
    end

    task automatic drain();
        while (q_id.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        drive_idle();
        repeat (3) @(negedge clk);
        check(!in_ready && !out_valid, "R1", "quiet during reset", int'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R6 first-frame latency, R7 two banks loaded then stall
        rdy_mode = 0;
        send_frame(0, 1'b0, 0, M, 1'b1);
        send_frame(1, 1'b1, 0, M, 1'b0);
        for (int c = 0; c < 4; c++) begin
            check(in_ready == 1'b0, "R7", "in_ready with both banks full", in_ready, 0);
            check(out_valid == 1'b1, "R7", "out_valid with both banks full", out_valid, 1);
            @(negedge clk);
        end
        rdy_mode = 2;
        send_frame(2, 1'b0, 2, M, 1'b0);
        send_frame(3, 1'b0, 0, M, 1'b0);
        send_frame(4, 1'b1, 0, M, 1'b0);

        // random mix of orders, gaps and back-pressure
        for (int f = 5; f < 40; f++) begin
            rdy_mode = (f % 5 == 0) ? 1 : 2;
            send_frame(f, 1'($urandom % 2), $urandom % 3, M, 1'b0);
        end
        rdy_mode = 1;
        drain();
        check(q_id.size() == 0 && !out_valid, "R9", "all frames drained",
              q_id.size(), 0);

        // R10 reset in the middle of a frame
        send_frame(100, 1'b1, 0, M / 2, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check(!in_ready && !out_valid, "R1", "quiet during mid-frame reset", int'(out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready && !out_valid, "R10", "state after mid-frame reset", int'(out_valid), 0);
        send_frame(101, 1'b0, 0, M, 1'b0);
        send_frame(102, 1'b1, 1, M, 1'b0);
        drain();
        check(q_id.size() == 0 && !out_valid, "R10", "frames after reset drained",
              q_id.size(), 0);
        finish_run();
    end

endmodule